// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Word Packing

This block buffers outgoing audio samples between a host register port and the serial link towards an audio codec. Every host word is turned into a 20-bit left-justified sample before it is stored, whatever width the host uses. In the packed mode a single 32-bit word carries two 16-bit halves, and each half becomes its own sample. On the codec side, samples leave as stereo pairs over a valid/ready handshake. A burst of pairs starts once the buffer is at least half full.

The host sets the run enable, the sample width, the packed mode and the two PCM slot enables with a control strobe. The block keeps four status flags current: empty, half-empty, full and underrun. These flags change on host pushes and on codec-side pops, following fixed update rules.

Top module: `pcm_tx_fifo`

## Requirements
- R1: After a synchronous reset, `level` is 0, `st_empty` and `st_half_empty` are 1, `st_full` and `st_underrun` are 0, and `pair_valid` is 0.
- R2: The sample width code is `ctl_size`: 0 is 16-bit, 1 is 18-bit, 2 is 20-bit, 3 is 12-bit. In unpacked mode the word is shifted left by 4, 2, 0 or 8 bits respectively and cut to 20 bits.
- R3: In packed mode, `wr_data[15:0]` is stored first and `wr_data[31:16]` second. Each half is shifted left by 8 bits for the 12-bit code and by 4 bits otherwise.
- R4: A packed-mode request together with the 18- or 20-bit code is stored as unpacked, so each write adds one sample.
- R5: An unpacked write is dropped when `level` equals DEPTH. A packed write is accepted only when `level` + 2 < DEPTH.
- R6: `pair_valid` needs `ctl_run` set and at least one bit of `ctl_slots` set. A burst starts only when `level` >= DEPTH/2. After a transfer, a burst continues while `level` >= 2.
- R7: A pair moves when `pair_valid` and `pair_ready` are both high. The older sample is on `pair_left` and the newer on `pair_right`, and `level` drops by 2. A cycle with `pair_ready` low moves nothing and ends a burst.
- R8: On every write request: a resulting level above 0 clears empty and underrun, a level at or above DEPTH/2 clears half-empty, and a level at or above DEPTH sets full.
- R9: On every transfer: full is cleared, a resulting level at or below DEPTH/2 sets half-empty, and a resulting level of 0 sets empty and underrun.
- R10: A write and a transfer in the same cycle both take effect. The write rules of R8 are applied first, then the transfer rules of R9.
- R11: The control fields are loaded only in a cycle with `ctl_we` high, and they take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Load the control fields |
| ctl_run | input | 1 | Transmit enable |
| ctl_size | input | 2 | Sample width code |
| ctl_pack | input | 1 | Request two 16-bit samples per word |
| ctl_slots | input | 2 | Left/right PCM slot enables |
| wr_en | input | 1 | Host sample write strobe |
| wr_data | input | 32 | Host sample word |
| pair_ready | input | 1 | Codec side accepts a pair |
| pair_valid | output | 1 | A stereo pair is offered |
| pair_left | output | 20 | Older sample of the pair |
| pair_right | output | 20 | Newer sample of the pair |
| level | output | clog2(DEPTH)+1 | Stored sample count |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |

## Verification
Writes, transfers and control loads are taken on a rising edge. `level` and the four flags show the result right after that edge. `pair_valid` and the pair data come directly from stored state, so they reflect a write or a control load from the cycle after it. The bench drives every input on the falling edge and advances its queue model by one step. It then compares every output on the following falling edge, which is exactly one rising edge after the stimulus. Pair data is compared only while the model says a pair is offered.

// File: rtl/pcm_txf_pkg.sv
package pcm_txf_pkg;
  localparam int SMP_W = 20;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_18 = 2'd1,
    SZ_20 = 2'd2,
    SZ_12 = 2'd3
  } smp_sz_e;

  typedef struct packed {
    logic       run;
    smp_sz_e    sz;
    logic       pack2;
    logic [1:0] slots;
  } txf_ctl_t;

  // Left-justify a whole host word into one sample
  function automatic logic [SMP_W-1:0] align_word(smp_sz_e sz, logic [31:0] w);
    logic [SMP_W-1:0] r;
    case (sz)
      SZ_12:   r = {w[11:0], 8'h00};
      SZ_16:   r = {w[15:0], 4'h0};
      SZ_18:   r = {w[17:0], 2'b00};
      default: r = w[19:0];
    endcase
    return r;
  endfunction

  // Left-justify one 16-bit half of a packed word
  function automatic logic [SMP_W-1:0] align_half(smp_sz_e sz, logic [15:0] h);
    logic [SMP_W-1:0] r;
    if (sz == SZ_12) r = {h[11:0], 8'h00};
    else             r = {h, 4'h0};
    return r;
  endfunction
endpackage

// File: rtl/pcm_txf_pack.sv
module pcm_txf_pack
  import pcm_txf_pkg::*;
(
  input  smp_sz_e          sz,
  input  logic             pack2,
  input  logic [31:0]      word,
  output logic [SMP_W-1:0] s_first,
  output logic [SMP_W-1:0] s_second
);
  always_comb begin
    s_first  = pack2 ? align_half(sz, word[15:0]) : align_word(sz, word);
    s_second = align_half(sz, word[31:16]);
  end
endmodule

// File: rtl/pcm_txf_banks.sv
module pcm_txf_banks
  import pcm_txf_pkg::*;
#(
  parameter int BANK_D = 4,
  parameter int BAW    = 2
) (
  input  logic                  clk,
  input  logic [1:0]            we,
  input  logic [1:0][BAW-1:0]   waddr,
  input  logic [1:0][SMP_W-1:0] wdata,
  input  logic [BAW-1:0]        raddr,
  output logic [1:0][SMP_W-1:0] rdata
);
  // Bank 0 holds even sample positions, bank 1 odd ones
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [SMP_W-1:0] mem [BANK_D];
    always_ff @(posedge clk) begin
      if (we[b]) mem[waddr[b]] <= wdata[b];
    end
    assign rdata[b] = mem[raddr];
  end
endmodule

// File: rtl/pcm_txf_status.sv
module pcm_txf_status #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [LW-1:0] lvl_push,
  input  logic [LW-1:0] lvl_final,
  output logic          empty,
  output logic          half_empty,
  output logic          full,
  output logic          underrun
);
  localparam int HALF = DEPTH / 2;

  logic e_n, h_n, f_n, u_n;

  always_comb begin
    e_n = empty;
    h_n = half_empty;
    f_n = full;
    u_n = underrun;
    if (push) begin
      if (lvl_push != '0) begin
        e_n = 1'b0;
        u_n = 1'b0;
      end
      if (int'(lvl_push) >= HALF)  h_n = 1'b0;
      if (int'(lvl_push) >= DEPTH) f_n = 1'b1;
    end
    if (pop) begin
      f_n = 1'b0;
      if (int'(lvl_final) <= HALF) h_n = 1'b1;
      if (lvl_final == '0) begin
        e_n = 1'b1;
        u_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty      <= 1'b1;
      half_empty <= 1'b1;
      full       <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      empty      <= e_n;
      half_empty <= h_n;
      full       <= f_n;
      underrun   <= u_n;
    end
  end
endmodule

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo
  import pcm_txf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_we,
  input  logic                   ctl_run,
  input  logic [1:0]             ctl_size,
  input  logic                   ctl_pack,
  input  logic [1:0]             ctl_slots,
  input  logic                   wr_en,
  input  logic [31:0]            wr_data,
  input  logic                   pair_ready,
  output logic                   pair_valid,
  output logic [SMP_W-1:0]       pair_left,
  output logic [SMP_W-1:0]       pair_right,
  output logic [$clog2(DEPTH):0] level,
  output logic                   st_empty,
  output logic                   st_half_empty,
  output logic                   st_full,
  output logic                   st_underrun
);
  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = AW + 1;
  localparam int HALF   = DEPTH / 2;
  localparam int BANK_D = DEPTH / 2;
  localparam int BAW    = AW - 1;

  txf_ctl_t ctl_q;
  smp_sz_e  sz_in;
  logic     pack_ok;

  logic [LW-1:0]  level_q, lvl_push, lvl_final;
  logic [AW-1:0]  wr_ptr_q, ptr_next2;
  logic [BAW-1:0] rd_idx_q;
  logic           burst_q;

  logic           room, pop;
  logic [1:0]     n_acc;
  logic [SMP_W-1:0] s_first, s_second;

  logic [1:0]            b_we;
  logic [1:0][BAW-1:0]   b_waddr;
  logic [1:0][SMP_W-1:0] b_wdata;
  logic [1:0][SMP_W-1:0] b_rdata;

  // Control fields; packing is refused for the 18- and 20-bit codes
  assign sz_in   = smp_sz_e'(ctl_size);
  assign pack_ok = ctl_pack && (sz_in == SZ_16 || sz_in == SZ_12);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q.run   <= ctl_run;
      ctl_q.sz    <= sz_in;
      ctl_q.pack2 <= pack_ok;
      ctl_q.slots <= ctl_slots;
    end
  end

  // Codec side: start at half full, keep going while pairs remain
  assign pair_valid = ctl_q.run && (|ctl_q.slots) &&
                      ((int'(level_q) >= HALF) || (burst_q && int'(level_q) >= 2));
  assign pop        = pair_valid && pair_ready;

  // Host side acceptance
  assign room  = ctl_q.pack2 ? (int'(level_q) + 2 < DEPTH) : (int'(level_q) < DEPTH);
  assign n_acc = (wr_en && room) ? (ctl_q.pack2 ? 2'd2 : 2'd1) : 2'd0;

  assign lvl_push  = level_q + LW'(n_acc);
  assign lvl_final = lvl_push - (pop ? LW'(2) : LW'(0));
  assign ptr_next2 = wr_ptr_q + AW'(1);

  pcm_txf_pack u_pack (
    .sz       (ctl_q.sz),
    .pack2    (ctl_q.pack2),
    .word     (wr_data),
    .s_first  (s_first),
    .s_second (s_second)
  );

  // Route each new sample to the bank chosen by its position parity
  always_comb begin
    b_we    = '0;
    b_waddr = '0;
    b_wdata = '0;
    if (n_acc != 2'd0) begin
      b_we[wr_ptr_q[0]]    = 1'b1;
      b_waddr[wr_ptr_q[0]] = wr_ptr_q[AW-1:1];
      b_wdata[wr_ptr_q[0]] = s_first;
    end
    if (n_acc == 2'd2) begin
      b_we[ptr_next2[0]]    = 1'b1;
      b_waddr[ptr_next2[0]] = ptr_next2[AW-1:1];
      b_wdata[ptr_next2[0]] = s_second;
    end
  end

  pcm_txf_banks #(.BANK_D(BANK_D), .BAW(BAW)) u_banks (
    .clk   (clk),
    .we    (b_we),
    .waddr (b_waddr),
    .wdata (b_wdata),
    .raddr (rd_idx_q),
    .rdata (b_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= '0;
      wr_ptr_q <= '0;
      rd_idx_q <= '0;
      burst_q  <= 1'b0;
    end else begin
      level_q  <= lvl_final;
      wr_ptr_q <= wr_ptr_q + AW'(n_acc);
      if (pop) rd_idx_q <= rd_idx_q + BAW'(1);
      burst_q  <= pop;
    end
  end

  pcm_txf_status #(.DEPTH(DEPTH), .LW(LW)) u_status (
    .clk        (clk),
    .rst        (rst),
    .push       (wr_en),
    .pop        (pop),
    .lvl_push   (lvl_push),
    .lvl_final  (lvl_final),
    .empty      (st_empty),
    .half_empty (st_half_empty),
    .full       (st_full),
    .underrun   (st_underrun)
  );

  assign pair_left  = b_rdata[0];
  assign pair_right = b_rdata[1];
  assign level      = level_q;
endmodule

// File: rtl/pcm_tx_fifo_chk.sv
module pcm_tx_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_we,
  input logic          wr_en,
  input logic          pair_ready,
  input logic          pair_valid,
  input logic [19:0]   pair_left,
  input logic [19:0]   pair_right,
  input logic [LW-1:0] level,
  input logic          st_empty,
  input logic          st_half_empty,
  input logic          st_full,
  input logic          st_underrun
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  initial begin
    p_depth_legal: assert (DEPTH >= 8 && DEPTH <= 2048 && (DEPTH & (DEPTH - 1)) == 0);
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (level == '0 && st_empty && st_half_empty && !st_full && !st_underrun && !pair_valid));

  p_level_cap_r5: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  p_burst_start_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && pair_valid && !$past(pair_valid && pair_ready)) |-> int'(level) >= DEPTH / 2);

  p_pair_present_r7: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> int'(level) >= 2);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && !pair_ready && !ctl_we && int'(level) >= DEPTH / 2)
      |=> (pair_valid && $stable(pair_left) && $stable(pair_right)));

  p_pop_step_r7: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && pair_ready && !wr_en) |=> level == $past(level) - LW'(2));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !(pair_valid && pair_ready)) |=> level == $past(level));

  p_full_level_r8: assert property (@(posedge clk) disable iff (rst)
    st_full |-> int'(level) == DEPTH);

  p_empty_level_r9: assert property (@(posedge clk) disable iff (rst)
    st_empty |-> level == '0);

  p_underrun_empty_r9: assert property (@(posedge clk) disable iff (rst)
    st_underrun |-> st_empty);
endmodule

bind pcm_tx_fifo pcm_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ctl_we        (ctl_we),
  .wr_en         (wr_en),
  .pair_ready    (pair_ready),
  .pair_valid    (pair_valid),
  .pair_left     (pair_left),
  .pair_right    (pair_right),
  .level         (level),
  .st_empty      (st_empty),
  .st_half_empty (st_half_empty),
  .st_full       (st_full),
  .st_underrun   (st_underrun)
);

// File: tb/pcm_tx_fifo_bench.sv
`timescale 1ns/1ps
module pcm_tx_fifo_bench;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, ctl_we, ctl_run, ctl_pack, wr_en, pair_ready;
  logic [1:0]    ctl_size, ctl_slots;
  logic [31:0]   wr_data;
  logic          pair_valid, st_empty, st_half_empty, st_full, st_underrun;
  logic [19:0]   pair_left, pair_right;
  logic [LW-1:0] level;

  pcm_tx_fifo #(.DEPTH(DEPTH)) u_pcm_tx_fifo (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_size(ctl_size),
    .ctl_pack(ctl_pack), .ctl_slots(ctl_slots), .wr_en(wr_en), .wr_data(wr_data),
    .pair_ready(pair_ready), .pair_valid(pair_valid), .pair_left(pair_left),
    .pair_right(pair_right), .level(level), .st_empty(st_empty),
    .st_half_empty(st_half_empty), .st_full(st_full), .st_underrun(st_underrun)
  );

  int n_chk = 0;
  int n_err = 0;

  // Reference model state
  int   mq[$];
  bit   m_run, m_pack, m_burst;
  int   m_sz;
  bit [1:0] m_sl;
  bit   m_e = 1, m_h = 1, m_f = 0, m_u = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int whole(int sz, bit [31:0] v);
    case (sz)
      3:       return int'((v << 8) & 32'hFFFFF);
      0:       return int'((v << 4) & 32'hFFFFF);
      1:       return int'((v << 2) & 32'hFFFFF);
      default: return int'(v & 32'hFFFFF);
    endcase
  endfunction

  function automatic int half16(int sz, bit [15:0] h);
    if (sz == 3) return int'({20'h0, h} * 256) & 32'hFFFFF;
    return int'({16'h0, h} * 16);
  endfunction

  function automatic bit m_valid();
    int n = mq.size();
    return m_run && (m_sl != 0) && (n >= HALF || (m_burst && n >= 2));
  endfunction

  task automatic compare();
    chk("R7 level", int'(level), mq.size());
    chk("R8 empty", st_empty, m_e);
    chk("R9 half-empty", st_half_empty, m_h);
    chk("R8 full", st_full, m_f);
    chk("R9 underrun", st_underrun, m_u);
    chk("R6 valid", pair_valid, m_valid());
    if (m_valid()) begin
      chk("R2 left sample", int'(pair_left), mq[0]);
      chk("R3 right sample", int'(pair_right), mq[1]);
    end
  endtask

  task automatic cyc(input bit cw, input bit run, input int sz, input bit pk,
                     input bit [1:0] sl, input bit w, input bit [31:0] d, input bit rdy);
    int  l0, l1;
    bit  pop;
    ctl_we = cw; ctl_run = run; ctl_size = 2'(sz); ctl_pack = pk; ctl_slots = sl;
    wr_en = w; wr_data = d; pair_ready = rdy;
    l0  = mq.size();
    pop = m_valid() && rdy;
    if (w) begin
      if (m_pack) begin
        if (l0 + 2 < DEPTH) begin
          mq.push_back(half16(m_sz, d[15:0]));
          mq.push_back(half16(m_sz, d[31:16]));
        end
      end else if (l0 < DEPTH) begin
        mq.push_back(whole(m_sz, d));
      end
      l1 = mq.size();
      if (l1 > 0) begin m_e = 0; m_u = 0; end
      if (l1 >= HALF) m_h = 0;
      if (l1 >= DEPTH) m_f = 1;
    end
    if (pop) begin
      void'(mq.pop_front());
      void'(mq.pop_front());
      m_f = 0;
      if (mq.size() <= HALF) m_h = 1;
      if (mq.size() == 0) begin m_e = 1; m_u = 1; end
    end
    m_burst = pop;
    if (cw) begin
      m_run = run; m_sz = sz; m_sl = sl;
      m_pack = pk && (sz == 0 || sz == 3);
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  // Control fields in wrd/idle are junk on purpose: ctl_we is low (R11)
  task automatic ctl(input bit run, input int sz, input bit pk, input bit [1:0] sl);
    cyc(1, run, sz, pk, sl, 0, 32'h0, 0);
  endtask
  task automatic wrd(input bit [31:0] d, input bit rdy);
    cyc(0, 0, 2, 1, 2'b00, 1, d, rdy);
  endtask
  task automatic idle(input bit rdy);
    cyc(0, 0, 1, 1, 2'b00, 0, 32'h0, rdy);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst = 1; ctl_we = 0; ctl_run = 0; ctl_size = 0; ctl_pack = 0; ctl_slots = 0;
    wr_en = 0; wr_data = 0; pair_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 empty", st_empty, 1);
    chk("R1 half-empty", st_half_empty, 1);
    chk("R1 full", st_full, 0);
    chk("R1 underrun", st_underrun, 0);
    chk("R1 valid", pair_valid, 0);
    compare();

    // R2: one sample of each width
    ctl(1, 3, 0, 2'b01);
    wrd(32'hFFFFF123, 0);
    chk("R8 empty cleared", st_empty, 0);
    ctl(1, 0, 0, 2'b01);
    wrd(32'h0000BEEF, 0);
    ctl(1, 1, 0, 2'b01);
    wrd(32'h0003FFFF, 0);
    ctl(1, 2, 0, 2'b01);
    wrd(32'h00FABCDE, 0);
    chk("R6 valid at half", pair_valid, 1);
    chk("R2 12-bit left", int'(pair_left), 'h12300);
    chk("R2 16-bit right", int'(pair_right), 'hBEEF0);
    chk("R8 half-empty cleared", st_half_empty, 0);
    chk("R11 ctl ignored without strobe", pair_valid, 1);
    idle(0);
    chk("R7 no move without ready", int'(level), 4);
    idle(1);
    chk("R7 level after pair", int'(level), 2);
    chk("R6 burst continues", pair_valid, 1);
    chk("R2 18-bit left", int'(pair_left), 'hFFFFC);
    chk("R2 20-bit right", int'(pair_right), 'hABCDE);
    idle(1);
    chk("R9 empty", st_empty, 1);
    chk("R9 underrun", st_underrun, 1);
    chk("R9 half-empty", st_half_empty, 1);

    // R3 packed mode
    ctl(1, 0, 1, 2'b01);
    wrd(32'h12345678, 0);
    chk("R8 underrun cleared", st_underrun, 0);
    chk("R6 no start below half", pair_valid, 0);
    ctl(1, 3, 1, 2'b01);
    wrd(32'h0ABC0DEF, 0);
    chk("R3 low half first", int'(pair_left), 'h56780);
    chk("R3 high half second", int'(pair_right), 'h12340);
    idle(1);
    chk("R3 12-bit packed left", int'(pair_left), 'hDEF00);
    chk("R3 12-bit packed right", int'(pair_right), 'hABC00);
    idle(0);
    chk("R7 ready drop ends burst", pair_valid, 0);

    // R4 packing refused for 18-bit
    ctl(1, 1, 1, 2'b01);
    wrd(32'h00012345, 0);
    chk("R4 one sample per word", int'(level), 3);
    wrd(32'h0, 0);
    idle(1);
    chk("R4 18-bit sample", int'(pair_left), 'h48D14);
    idle(1);

    // R5 fill and overflow
    ctl(1, 0, 0, 2'b01);
    for (int i = 0; i < DEPTH; i++) wrd(32'(i + 1), 0);
    chk("R8 full set", st_full, 1);
    wrd(32'h99, 0);
    chk("R5 dropped at depth", int'(level), DEPTH);
    idle(1);
    chk("R9 full cleared", st_full, 0);
    ctl(1, 0, 1, 2'b01);
    wrd(32'h11112222, 0);
    chk("R5 packed refused at depth-2", int'(level), DEPTH - 2);
    wrd(32'h33334444, 1);
    chk("R10 dropped write plus pair", int'(level), DEPTH - 4);
    wrd(32'h55556666, 1);
    chk("R10 write plus pair", int'(level), DEPTH - 4);
    idle(0);

    // R6 enables
    ctl(1, 0, 0, 2'b00);
    idle(1);
    chk("R6 no slots", pair_valid, 0);
    ctl(0, 0, 0, 2'b10);
    idle(1);
    chk("R6 not running", pair_valid, 0);
    ctl(1, 0, 0, 2'b10);
    chk("R6 right slot only", pair_valid, 1);
    cyc(0, 0, 0, 0, 2'b00, 0, 32'h0, 0);
    chk("R11 run kept", pair_valid, 1);

    // Mixed random traffic
    for (int k = 0; k < 600; k++) begin
      cyc(($urandom % 12) == 0, ($urandom % 8) != 0, int'($urandom % 4), $urandom % 2,
          2'($urandom % 4), $urandom % 2, $urandom, ($urandom % 3) != 0);
    end

    finish_run();
  end
endmodule